// File: doc/BRIEF.md
# Command Post and Completion Register Block

This block is the controller-side register window through which a host posts command addresses and collects completions in simple (non-queued-interrupt) mode. The host reaches it over a 32-bit memory-mapped port with a one-cycle valid/ready handshake. A write to the request port places a command bus address into a request FIFO, which the command-processing side drains through a pop port. The processing side returns completion tags through a push port into a reply FIFO, and the host takes them out by reading the reply port.

Next to the two FIFOs sit an interrupt mask, an interrupt status word, a doorbell word and a read-only readiness scratchpad. The mask has inverted polarity: a set bit turns the interrupt off and a cleared bit turns it on. Reading the reply port while it holds nothing returns an all-ones sentinel and never stalls. The block counts commands in flight and flags when that count reaches the command limit, so the host can stop posting. A request posted while the request FIFO is full is dropped and leaves a sticky error flag.

The bus side runs on a two-state access machine. IDLE goes to RESP when a valid request is taken. All side effects happen on that transition. RESP goes back to IDLE on the next cycle, and ready is high only while in RESP.

Top module: `cmdq_mmio_regs`

## Requirements
- R1: A write to offset 0x40 pushes the 32-bit write data into the request FIFO. The processing side sees the entries in write order on `req_data`, with `req_valid` high while any entry is held, and `req_pop` removes the head.
- R2: A write to offset 0x40 while the request FIFO is full is dropped, and sets bit 1 of the status word. That bit stays set until reset.
- R3: A read at offset 0x44 returns the oldest reply and removes it. When the reply FIFO is empty the read returns 0xFFFFFFFF and changes no state. This includes the in-flight count.
- R4: The mask word at offset 0x34 stores bit 3 only. 1 disables the interrupt and 0 enables it. It resets to 0x08 and reads back as written in bit 3, with all other bits zero.
- R5: The status word at offset 0x30 has bit 3 set exactly when the reply FIFO is non-empty and the mask bit is clear. The `irq` output follows the same condition. The other bits are zero, except bit 1 (R2).
- R6: The scratchpad at offset 0xB0 reads 0xFFFF0000 while `fw_ready` is high and 0 otherwise. Writes to it have no effect.
- R7: A write to the doorbell at offset 0x20 stores the full word. The stored word is read back at 0x20 and driven on `db_value`.
- R8: The in-flight count rises by one for each accepted request write and falls by one for each non-empty reply read. `cmd_full` is high while the count is at or above CMD_LIMIT (default 4).
- R9: A read of any other offset returns 0, and a write to any other offset changes nothing.
- R10: `bus_ready` rises in the cycle after a valid access is taken and lasts exactly one cycle. `bus_rdata` is valid while ready is high, and is 0 for a write.
- R11: After reset: `irq` low, `req_valid` low, `cmd_full` low, `rsp_space` high, `db_value` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access complete, one cycle |
| bus_rdata | output | 32 | Read data, valid with ready |
| fw_ready | input | 1 | Controller readiness for the scratchpad |
| req_pop | input | 1 | Processing side removes the head request |
| req_valid | output | 1 | Request FIFO holds an entry |
| req_data | output | 32 | Head request address |
| rsp_push | input | 1 | Processing side posts a reply |
| rsp_data | input | 32 | Reply tag to post |
| rsp_space | output | 1 | Reply FIFO can take an entry |
| irq | output | 1 | Interrupt, reply pending and unmasked |
| cmd_full | output | 1 | In-flight count at the command limit |
| db_value | output | 32 | Last doorbell word |

## Verification
A host access driven before clock edge k has all of its effects in place after edge k. The read data and `bus_ready` are sampled at the falling edge that follows, and `req_valid`, `irq` and `cmd_full` are also checked at that falling edge. A push or pop on the processing side is applied at one rising edge, and its result on `irq`, `req_data` or the status word is checked no earlier than the next falling edge. The bench drops `bus_valid` at the falling edge where it sees ready, then leaves one idle cycle before the next access, so the access machine is always in IDLE when a new request arrives.

// File: rtl/rrq_pkg.sv
package rrq_pkg;

    localparam logic [7:0] OFF_DOORBELL = 8'h20;
    localparam logic [7:0] OFF_STATUS   = 8'h30;
    localparam logic [7:0] OFF_MASK     = 8'h34;
    localparam logic [7:0] OFF_REQ      = 8'h40;
    localparam logic [7:0] OFF_REPLY    = 8'h44;
    localparam logic [7:0] OFF_SCRATCH  = 8'hB0;

    localparam logic [31:0] REPLY_NONE  = 32'hFFFF_FFFF;
    localparam logic [31:0] READY_WORD  = 32'hFFFF_0000;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;

    function automatic logic is_mapped(input logic [7:0] a);
        return (a == OFF_DOORBELL) || (a == OFF_STATUS) || (a == OFF_MASK) ||
               (a == OFF_REQ) || (a == OFF_REPLY) || (a == OFF_SCRATCH);
    endfunction

endpackage

// File: rtl/rrq_fifo.sv
module rrq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/rrq_bus_fsm.sv
module rrq_bus_fsm
    import rrq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_valid,
    output logic acc_fire,
    output logic bus_ready
);
    acc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        acc_fire  = 1'b0;
        bus_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: acc_fire  = bus_valid;
            ST_RESP: bus_ready = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cmdq_mmio_regs.sv
module cmdq_mmio_regs
    import rrq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CMD_LIMIT  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_ready,
    output logic [31:0] bus_rdata,
    input  logic        fw_ready,
    input  logic        req_pop,
    output logic        req_valid,
    output logic [31:0] req_data,
    input  logic        rsp_push,
    input  logic [31:0] rsp_data,
    output logic        rsp_space,
    output logic        irq,
    output logic        cmd_full,
    output logic [31:0] db_value
);
    localparam int OW = $clog2(CMD_LIMIT + 1);
    localparam logic [OW-1:0] LIMIT = OW'(CMD_LIMIT);

    logic        acc_fire, wr_fire, rd_fire;
    logic        req_push, req_full, req_empty;
    logic        rsp_pop, rsp_full, rsp_empty;
    logic [31:0] rsp_head;
    logic        mask_q, ovf_q, pending;
    logic [31:0] db_q, rdata_q;
    logic [OW-1:0] outst_q;

    rrq_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .acc_fire  (acc_fire),
        .bus_ready (bus_ready)
    );

    assign wr_fire  = acc_fire && bus_write;
    assign rd_fire  = acc_fire && !bus_write;
    assign req_push = wr_fire && (bus_addr == OFF_REQ);
    assign rsp_pop  = rd_fire && (bus_addr == OFF_REPLY) && !rsp_empty;

    rrq_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_reqq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (req_push),
        .din   (bus_wdata),
        .pop   (req_pop),
        .dout  (req_data),
        .full  (req_full),
        .empty (req_empty)
    );

    rrq_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rspq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rsp_push),
        .din   (rsp_data),
        .pop   (rsp_pop),
        .dout  (rsp_head),
        .full  (rsp_full),
        .empty (rsp_empty)
    );

    assign req_valid = !req_empty;
    assign rsp_space = !rsp_full;
    assign pending   = !rsp_empty && !mask_q;
    assign irq       = pending;
    assign cmd_full  = (outst_q >= LIMIT);
    assign db_value  = db_q;
    assign bus_rdata = rdata_q;

    // control registers: mask (set = off), doorbell, sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            db_q   <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_fire && bus_addr == OFF_MASK)     mask_q <= bus_wdata[3];
            if (wr_fire && bus_addr == OFF_DOORBELL) db_q   <= bus_wdata;
            if (req_push && req_full)                ovf_q  <= 1'b1;
        end
    end

    // in-flight command count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else if (req_push && !req_full) begin
            if (outst_q != LIMIT) outst_q <= outst_q + 1'b1;
        end else if (rsp_pop) begin
            if (outst_q != '0) outst_q <= outst_q - 1'b1;
        end
    end

    // registered read data, captured at access acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (wr_fire) begin
            rdata_q <= '0;
        end else if (rd_fire) begin
            unique case (bus_addr)
                OFF_DOORBELL: rdata_q <= db_q;
                OFF_STATUS:   rdata_q <= {28'd0, pending, 1'b0, ovf_q, 1'b0};
                OFF_MASK:     rdata_q <= {28'd0, mask_q, 3'd0};
                OFF_REPLY:    rdata_q <= rsp_empty ? REPLY_NONE : rsp_head;
                OFF_SCRATCH:  rdata_q <= fw_ready ? READY_WORD : 32'd0;
                default:      rdata_q <= 32'd0;
            endcase
        end
    end

endmodule

// File: rtl/cmdq_mmio_regs_chk.sv
module cmdq_mmio_regs_chk
    import rrq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_fire,
    input logic        bus_write,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ready,
    input logic [31:0] bus_rdata,
    input logic        rsp_empty,
    input logic        ovf_q,
    input logic        irq
);
    // R10: ready follows a taken access and lasts one cycle
    a_r10_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fire |=> bus_ready);
    a_r10_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R3: empty reply port returns the sentinel
    a_r3_empty_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && !bus_write && bus_addr == OFF_REPLY && rsp_empty)
        |=> (bus_rdata == REPLY_NONE));

    // R4: setting the mask bit silences the interrupt
    a_r4_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && bus_write && bus_addr == OFF_MASK && bus_wdata[3]) |=> !irq);

    // R2: overflow flag never clears once set
    a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R9: unmapped reads return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && !bus_write && !is_mapped(bus_addr)) |=> (bus_rdata == 32'd0));

endmodule

bind cmdq_mmio_regs cmdq_mmio_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_fire  (acc_fire),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .rsp_empty (rsp_empty),
    .ovf_q     (ovf_q),
    .irq       (irq)
);

// File: tb/cmdq_mmio_regs_test.sv
`timescale 1ns/1ps
module cmdq_mmio_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        fw_ready = 1'b1;
    logic        req_pop = 1'b0;
    logic        req_valid;
    logic [31:0] req_data;
    logic        rsp_push = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        rsp_space, irq, cmd_full;
    logic [31:0] db_value;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cmdq_mmio_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .fw_ready(fw_ready), .req_pop(req_pop),
        .req_valid(req_valid), .req_data(req_data), .rsp_push(rsp_push),
        .rsp_data(rsp_data), .rsp_space(rsp_space), .irq(irq),
        .cmd_full(cmd_full), .db_value(db_value)
    );

    // {write, addr, wdata, expected rdata}
    localparam int NV = 13;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'hB0, 32'h0,        32'hFFFF0000},  // R6 ready word
        {1'b0, 8'h34, 32'h0,        32'h00000008},  // R4 reset mask
        {1'b0, 8'h44, 32'h0,        32'hFFFFFFFF},  // R3 empty reply
        {1'b0, 8'h30, 32'h0,        32'h00000000},  // R5 nothing pending
        {1'b1, 8'h20, 32'h1234ABCD, 32'h00000000},  // R7 doorbell write
        {1'b0, 8'h20, 32'h0,        32'h1234ABCD},  // R7 read back
        {1'b0, 8'h10, 32'h0,        32'h00000000},  // R9 unmapped read
        {1'b1, 8'h34, 32'h0,        32'h00000000},  // R4 enable
        {1'b0, 8'h34, 32'h0,        32'h00000000},  // R4 read back
        {1'b1, 8'hB0, 32'hDEADBEEF, 32'h00000000},  // R6 write ignored
        {1'b0, 8'hB0, 32'h0,        32'hFFFF0000},  // R6
        {1'b1, 8'h24, 32'h00000055, 32'h00000000},  // R9 unmapped write
        {1'b0, 8'h20, 32'h0,        32'h1234ABCD}   // R9 doorbell untouched
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        check("R10 ready", {31'd0, bus_ready}, 32'd1);
        rd = bus_rdata;
        bus_valid = 1'b0;
        @(negedge clk);
        check("R10 ready drop", {31'd0, bus_ready}, 32'd0);
    endtask

    task automatic push_reply(input logic [31:0] d);
        @(negedge clk);
        rsp_push = 1'b1; rsp_data = d;
        @(negedge clk);
        rsp_push = 1'b0;
    endtask

    task automatic pop_req(input logic [31:0] exp);
        @(negedge clk);
        check("R1 req_valid", {31'd0, req_valid}, 32'd1);
        check("R1 req_data order", req_data, exp);
        req_pop = 1'b1;
        @(negedge clk);
        req_pop = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 irq", {31'd0, irq}, 32'd0);
        check("R11 req_valid", {31'd0, req_valid}, 32'd0);
        check("R11 cmd_full", {31'd0, cmd_full}, 32'd0);
        check("R11 rsp_space", {31'd0, rsp_space}, 32'd1);
        check("R11 db_value", db_value, 32'd0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][72], VEC[i][71:64], VEC[i][63:32], rd);
            check($sformatf("vector %0d", i), rd, VEC[i][31:0]);
        end
        check("R7 db_value", db_value, 32'h1234ABCD);

        // R1/R8: four requests fill the command limit
        for (int i = 0; i < 4; i++) begin
            access(1'b1, 8'h40, 32'hA000_0000 + i, rd);
            check("R8 cmd_full rising", {31'd0, cmd_full}, (i == 3) ? 32'd1 : 32'd0);
        end
        check("R2 no overflow yet", {31'd0, 1'b0}, 32'd0);
        access(1'b0, 8'h30, 32'h0, rd);
        check("R2 status clean", rd, 32'h0);
        // R2: fifth write dropped
        access(1'b1, 8'h40, 32'hBBBB_BBBB, rd);
        access(1'b0, 8'h30, 32'h0, rd);
        check("R2 overflow bit", rd, 32'h2);
        for (int i = 0; i < 4; i++) pop_req(32'hA000_0000 + i);
        @(negedge clk);
        check("R2 dropped entry absent", {31'd0, req_valid}, 32'd0);

        // R5: replies raise irq while enabled
        push_reply(32'hC0DE_0001);
        check("R5 irq on", {31'd0, irq}, 32'd1);
        push_reply(32'hC0DE_0002);
        access(1'b0, 8'h30, 32'h0, rd);
        check("R5 status pending", rd, 32'hA);
        access(1'b1, 8'h34, 32'h8, rd);
        check("R4 irq masked", {31'd0, irq}, 32'd0);
        access(1'b0, 8'h30, 32'h0, rd);
        check("R5 masked status", rd, 32'h2);

        // R3/R8: reply reads in order, count falls
        access(1'b0, 8'h44, 32'h0, rd);
        check("R3 first reply", rd, 32'hC0DE_0001);
        check("R8 cmd_full falls", {31'd0, cmd_full}, 32'd0);
        access(1'b0, 8'h44, 32'h0, rd);
        check("R3 second reply", rd, 32'hC0DE_0002);
        access(1'b0, 8'h44, 32'h0, rd);
        check("R3 sentinel", rd, 32'hFFFFFFFF);
        // count is now 2; two more requests reach the limit
        access(1'b1, 8'h40, 32'h1, rd);
        access(1'b1, 8'h40, 32'h2, rd);
        check("R8 full again", {31'd0, cmd_full}, 32'd1);
        access(1'b0, 8'h44, 32'h0, rd);
        check("R3 empty read sentinel", rd, 32'hFFFFFFFF);
        check("R3 empty read keeps count", {31'd0, cmd_full}, 32'd1);
        access(1'b0, 8'h30, 32'h0, rd);
        check("R2 overflow sticky", rd, 32'h2);

        // R6: scratchpad without readiness
        fw_ready = 1'b0;
        access(1'b0, 8'hB0, 32'h0, rd);
        check("R6 not ready", rd, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule